// File: doc/BRIEF.md
# Serial EEPROM Page Write Controller

This block is the memory-side engine of a two-wire serial EEPROM slave. A byte-level front end (not part of this block) hands it decoded events: an address load carrying three block-select bits and a word address, incoming write data bytes, a STOP indication and read requests. The controller keeps an 11-bit address pointer. It gathers write data in a 16-byte page latch and, once STOP closes a write sequence, commits the latched page to a byte-wide synchronous memory array of 2048 bytes during a self-timed write cycle. A busy flag is raised for the whole of that cycle.

While a sequence is open, only the low four pointer bits move, so writes stay inside one 16-byte page. When more than sixteen bytes arrive, the later bytes replace the earlier ones. Only latch slots that were filled in the current sequence are written; the rest of the page keeps its stored contents. A write-protect input turns the part into a read-only memory. Reads fetch the byte at the pointer and advance the full pointer linearly.

Top module: `eeprom_page_writer`

## Requirements
- R1: An address load places the block-select bits in pointer bits 10..8 and the word address in bits 7..0, so the byte is stored at array location {blk, word}.
- R2: The first data byte of a sequence goes to the latch slot of pointer bits 3..0. Each accepted byte then adds one to bits 3..0 only, and bits 10..4 stay fixed.
- R3: When bits 3..0 pass 15 they wrap to 0 within the same page. A byte that lands on a slot already filled replaces it, so after more than 16 bytes only the last 16 are kept.
- R4: The array is never written (mem_we low) outside the write cycle. Nothing from a sequence reaches the array before STOP.
- R5: A commit writes only the slots filled in the current sequence. Other locations of the page keep their old contents.
- R6: A STOP that ends a sequence with at least one data byte and write-protect low raises busy from the next cycle, for exactly WRITE_CYCLES cycles.
- R7: If wp is high when STOP arrives, no array location changes and busy stays low. Reads still return stored data.
- R8: A read request returns the byte at the pointer on rdata, with rdata_valid high, in the cycle after the request. The pointer then advances as a full 11-bit value and wraps from 0x7FF to 0x000.
- R9: A sequence that ends in STOP with no data byte only moves the pointer and does not raise busy.
- R10: While busy is high, address loads, data bytes and read requests are ignored: they do not change the pointer, the array or rdata_valid.
- R11: A data byte that arrives in the same cycle as STOP belongs to the sequence and is committed with it.
- R12: After reset, busy, rdata_valid and mem_we are low and the pointer is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address load event; opens a write sequence |
| addr_blk | input | 3 | Block-select bits of the address |
| addr_word | input | 8 | Word address byte |
| wdata_valid | input | 1 | Write data byte event |
| wdata | input | 8 | Write data byte |
| stop_evt | input | 1 | STOP condition seen on the bus |
| rd_req | input | 1 | Request for one read byte |
| wp | input | 1 | Write protect for the whole array |
| busy | output | 1 | Self-timed write cycle in progress |
| rdata_valid | output | 1 | rdata holds a read byte |
| rdata | output | 8 | Read byte |
| mem_we | output | 1 | Array write enable |
| mem_re | output | 1 | Array read enable (one-cycle latency) |
| mem_addr | output | 11 | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid the cycle after mem_re |

## Verification
The collision of interest is the last data byte and STOP arriving in one cycle: the latch write and the start of the commit then share one clock edge. The bench drives wdata_valid and stop_evt together, and that byte also wraps the page column from 15 to 0. It then reads both target locations back through the read path. The byte must be present at the wrapped location, and busy must last its full length. A second overlap, commands issued while the write cycle runs, is judged by showing that the pointer and array are unchanged once busy falls.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

    // Array geometry
    localparam int BLK_W      = 3;
    localparam int WORD_W     = 8;
    localparam int ADDR_W     = BLK_W + WORD_W;
    localparam int COL_W      = 4;
    localparam int PAGE_W     = ADDR_W - COL_W;
    localparam int PAGE_BYTES = 1 << COL_W;
    localparam int DATA_W     = 8;

    // Pointer split into the fixed page part and the wrapping column
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
    } ptr_t;

    typedef enum logic [1:0] {
        CM_IDLE,
        CM_PROG,
        CM_HOLD
    } cm_state_e;

    function automatic ptr_t make_ptr(input logic [BLK_W-1:0] blk,
                                      input logic [WORD_W-1:0] word);
        logic [ADDR_W-1:0] flat;
        flat = {blk, word};
        return ptr_t'(flat);
    endfunction

    function automatic ptr_t col_step(input ptr_t p);
        ptr_t r;
        r      = p;
        r.col  = p.col + 1'b1;
        return r;
    endfunction

    function automatic ptr_t lin_step(input ptr_t p);
        logic [ADDR_W-1:0] flat;
        flat = p;
        flat = flat + 1'b1;
        return ptr_t'(flat);
    endfunction

endpackage

// File: rtl/eeprom_pw_pointer.sv
module eeprom_pw_pointer
    import eeprom_pw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  ptr_t load_val,
    input  logic step_col,
    input  logic step_lin,
    output ptr_t ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step_col) begin
            ptr <= col_step(ptr);
        end else if (step_lin) begin
            ptr <= lin_step(ptr);
        end
    end

    // Column steps never move the page part
    assert_page_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (step_col && !load) |=> (ptr.page == $past(ptr.page)));

    // Linear stepping wraps at the top of the array
    assert_lin_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (step_lin && !load && !step_col && ptr == '1) |=> (ptr == '0));

endmodule

// File: rtl/eeprom_pw_latch.sv
module eeprom_pw_latch
    import eeprom_pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [COL_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);

    logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic              v;
        logic              hit;

        assign hit = wr_en && (wr_idx == COL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v <= 1'b0;
            end else if (clear) begin
                v <= 1'b0;
            end else if (hit) begin
                v <= 1'b1;
            end
        end

        // Data needs no reset: a slot is only read while its valid bit is set
        always_ff @(posedge clk) begin
            if (hit) begin
                q <= wr_data;
            end
        end

        assign slot_data[g] = q;
        assign slot_vld[g]  = v;
    end

    assign rd_data = slot_data[rd_idx];
    assign rd_vld  = slot_vld[rd_idx];
    assign any_vld = |slot_vld;

    // A new sequence starts with an empty latch
    assert_clear_empty_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !any_vld);

endmodule

// File: rtl/eeprom_pw_commit.sv
module eeprom_pw_commit
    import eeprom_pw_pkg::*;
#(
    // Must exceed PAGE_BYTES: the scan of the latch sits inside the cycle
    parameter int WRITE_CYCLES = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  lat_idx,
    input  logic              lat_vld,
    input  logic [DATA_W-1:0] lat_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES - 1);

    cm_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CM_IDLE;
            cnt    <= '0;
            page_q <= '0;
        end else begin
            unique case (state)
                CM_IDLE: begin
                    if (start) begin
                        state  <= CM_PROG;
                        cnt    <= '0;
                        page_q <= page;
                    end
                end
                CM_PROG: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == SCAN_END) begin
                        state <= CM_HOLD;
                    end
                end
                CM_HOLD: begin
                    if (cnt == LAST_CNT) begin
                        state <= CM_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= CM_IDLE;
            endcase
        end
    end

    assign busy      = (state != CM_IDLE);
    assign lat_idx   = cnt[COL_W-1:0];
    assign mem_we    = (state == CM_PROG) && lat_vld;
    assign mem_addr  = {page_q, lat_idx};
    assign mem_wdata = lat_data;

    // The write cycle only begins on a commit request
    assert_busy_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int WRITE_CYCLES = 500
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_valid,
    input  logic [BLK_W-1:0]   addr_blk,
    input  logic [WORD_W-1:0]  addr_word,
    input  logic               wdata_valid,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               stop_evt,
    input  logic               rd_req,
    input  logic               wp,
    output logic               busy,
    output logic               rdata_valid,
    output logic [DATA_W-1:0]  rdata,
    output logic               mem_we,
    output logic               mem_re,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    ptr_t              ptr;
    logic              seq_active;
    logic              addr_take;
    logic              data_take;
    logic              stop_take;
    logic              rd_take;
    logic              commit_go;
    logic [COL_W-1:0]  lat_idx;
    logic [DATA_W-1:0] lat_data;
    logic              lat_vld;
    logic              lat_any;
    logic [ADDR_W-1:0] cm_addr;

    // Command acceptance: nothing is taken while the write cycle runs
    assign addr_take = addr_valid && !busy;
    assign data_take = wdata_valid && seq_active && !busy && !addr_valid;
    assign stop_take = stop_evt && seq_active && !busy && !addr_valid;
    assign rd_take   = rd_req && !busy && !seq_active && !addr_valid;
    assign commit_go = stop_take && !wp && (lat_any || data_take);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_active  <= 1'b0;
            rdata_valid <= 1'b0;
        end else begin
            if (addr_take) begin
                seq_active <= 1'b1;
            end else if (stop_take) begin
                seq_active <= 1'b0;
            end
            rdata_valid <= rd_take;
        end
    end

    eeprom_pw_pointer u_pointer (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_take),
        .load_val (make_ptr(addr_blk, addr_word)),
        .step_col (data_take),
        .step_lin (rd_take),
        .ptr      (ptr)
    );

    eeprom_pw_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .clear   (addr_take),
        .wr_en   (data_take),
        .wr_idx  (ptr.col),
        .wr_data (wdata),
        .rd_idx  (lat_idx),
        .rd_data (lat_data),
        .rd_vld  (lat_vld),
        .any_vld (lat_any)
    );

    eeprom_pw_commit #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_commit (
        .clk       (clk),
        .rst       (rst),
        .start     (commit_go),
        .page      (ptr.page),
        .lat_idx   (lat_idx),
        .lat_vld   (lat_vld),
        .lat_data  (lat_data),
        .mem_we    (mem_we),
        .mem_addr  (cm_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy)
    );

    assign mem_re   = rd_take;
    assign mem_addr = busy ? cm_addr : ADDR_W'(ptr);
    assign rdata    = mem_rdata;

    // Array writes only happen inside the self-timed cycle
    assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // Protected STOP never starts a cycle
    assert_wp_no_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && wp && !busy) |=> !busy);

    // Reads are refused during the write cycle
    assert_busy_no_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && busy) |=> !rdata_valid);

endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
    import eeprom_pw_pkg::*;

    localparam int WC = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic [2:0]  addr_blk = '0;
    logic [7:0]  addr_word = '0;
    logic        wdata_valid = 1'b0;
    logic [7:0]  wdata = '0;
    logic        stop_evt = 1'b0;
    logic        rd_req = 1'b0;
    logic        wp = 1'b0;
    logic        busy, rdata_valid, mem_we, mem_re;
    logic [7:0]  rdata, mem_wdata;
    logic [10:0] mem_addr;
    logic [7:0]  mem_rdata;

    always #5 clk = ~clk;

    eeprom_page_writer #(.WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr_blk(addr_blk),
        .addr_word(addr_word), .wdata_valid(wdata_valid), .wdata(wdata),
        .stop_evt(stop_evt), .rd_req(rd_req), .wp(wp), .busy(busy),
        .rdata_valid(rdata_valid), .rdata(rdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Synchronous RAM model of the array
    logic [7:0] ram [2048];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    // Reference model
    logic [7:0] exp_mem [2048];
    int         m_ptr = 0;
    logic [7:0] m_lat [16];
    bit         m_lv  [16];
    bit         m_seq = 0;

    int total = 0;
    int fails = 0;
    int we_seen = 0;
    logic [7:0] exp_v [$];
    string      exp_t [$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rdata_valid) begin
                if (exp_v.size() == 0) begin
                    check(0, "R10 unexpected read data", rdata, 0);
                end else begin
                    automatic logic [7:0] e = exp_v.pop_front();
                    automatic string t = exp_t.pop_front();
                    check(rdata == e, t, rdata, e);
                end
            end
            if (mem_we) begin
                we_seen++;
                check(busy, "R4 write outside cycle", mem_we, 0);
            end
        end
    end

    // Model helpers
    task automatic m_put(input logic [7:0] d);
        m_lat[m_ptr & 15] = d;
        m_lv[m_ptr & 15]  = 1;
        m_ptr = (m_ptr & 'h7F0) | ((m_ptr + 1) & 15);
    endtask

    function automatic int m_stop();
        bit any = 0;
        int res = 0;
        for (int i = 0; i < 16; i++) any |= m_lv[i];
        if (m_seq && any && !wp) begin
            for (int i = 0; i < 16; i++)
                if (m_lv[i]) exp_mem[(m_ptr & 'h7F0) | i] = m_lat[i];
            res = WC;
        end
        m_seq = 0;
        return res;
    endfunction

    // Drivers: called just after a falling edge
    task automatic set_addr(input int blk, input int word);
        addr_valid = 1; addr_blk = 3'(blk); addr_word = 8'(word);
        @(negedge clk);
        addr_valid = 0;
        m_ptr = blk * 256 + word;
        m_seq = 1;
        for (int i = 0; i < 16; i++) m_lv[i] = 0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        wdata_valid = 1; wdata = d;
        @(negedge clk);
        wdata_valid = 0;
        m_put(d);
    endtask

    task automatic time_busy(input int expw, input string tag);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == expw, tag, n, expw);
    endtask

    task automatic stop_timed(input string tag);
        int expw;
        expw = m_stop();
        stop_evt = 1;
        @(negedge clk);
        stop_evt = 0;
        time_busy(expw, tag);
    endtask

    task automatic data_stop(input logic [7:0] d, input string tag);
        int expw;
        m_put(d);
        expw = m_stop();
        wdata_valid = 1; wdata = d; stop_evt = 1;
        @(negedge clk);
        wdata_valid = 0; stop_evt = 0;
        time_busy(expw, tag);
    endtask

    task automatic read_n(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_v.push_back(exp_mem[m_ptr]);
            exp_t.push_back(tag);
            rd_req = 1;
            @(negedge clk);
            rd_req = 0;
            m_ptr = (m_ptr + 1) & 'h7FF;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            ram[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 16; i++) begin m_lv[i] = 0; m_lat[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R12: reset state
        check(busy == 0, "R12 busy", busy, 0);
        check(rdata_valid == 0, "R12 rdata_valid", rdata_valid, 0);
        check(mem_we == 0, "R12 mem_we", mem_we, 0);
        read_n(1, "R12 pointer at 0");

        // R1 R6: single byte write then readback with neighbours
        set_addr(5, 'h23);
        put_byte(8'hA5);
        stop_timed("R6 busy length");
        set_addr(5, 'h22);
        stop_timed("R9 address only no busy");
        read_n(3, "R1 R5 byte write readback");

        // R3 R4: 20 bytes from column 0xA wrap inside the page
        set_addr(2, 'h3A);
        we_seen = 0;
        for (int i = 0; i < 20; i++) put_byte(8'(8'h40 + i));
        check(we_seen == 0, "R4 no write before STOP", we_seen, 0);
        stop_timed("R6 busy length page");
        set_addr(2, 'h30);
        stop_timed("R9 address only");
        read_n(16, "R3 wrap overwrite");
        read_n(1, "R2 next page untouched");

        // R8: linear read wraps from 0x7FF to 0x000
        set_addr(7, 'hFE);
        stop_timed("R9 address only");
        read_n(4, "R8 linear read wrap");

        // R7: write protect
        wp = 1;
        set_addr(1, 'h10);
        put_byte(8'h5A);
        put_byte(8'h6B);
        stop_timed("R7 no busy under wp");
        set_addr(1, 'h10);
        stop_timed("R7 address only");
        read_n(2, "R7 array unchanged");
        wp = 0;

        // R10: commands during busy are ignored
        set_addr(3, 'h40);
        put_byte(8'h11);
        begin
            void'(m_stop());
            stop_evt = 1;
            @(negedge clk);
            stop_evt = 0;
            check(busy == 1, "R10 busy raised", busy, 1);
            addr_valid = 1; addr_blk = 3'd6; addr_word = 8'h00;
            @(negedge clk);
            addr_valid = 0;
            wdata_valid = 1; wdata = 8'h99;
            @(negedge clk);
            wdata_valid = 0;
            rd_req = 1;
            @(negedge clk);
            rd_req = 0;
            while (busy) @(negedge clk);
            @(negedge clk);
        end
        read_n(1, "R10 pointer kept");
        set_addr(6, 'h00);
        stop_timed("R9 address only");
        read_n(1, "R10 array kept");
        set_addr(3, 'h40);
        stop_timed("R9 address only");
        read_n(1, "R10 committed byte");

        // R11: data byte and STOP in one cycle, column wrap 15 -> 0
        set_addr(4, 'h0F);
        put_byte(8'h21);
        data_stop(8'h22, "R11 busy length");
        set_addr(4, 'h0F);
        stop_timed("R9 address only");
        read_n(1, "R11 first byte");
        set_addr(4, 'h00);
        stop_timed("R9 address only");
        read_n(2, "R11 same-cycle byte");

        check(exp_v.size() == 0, "R8 all reads returned", exp_v.size(), 0);
        finish_run();
    end

endmodule